// File: doc/BRIEF.md
# Renaming Architectural Register File

This block holds the architectural integer registers of an out-of-order core together with the rename bookkeeping for each one. Alongside every register's committed value it keeps a pending flag and the reorder-buffer tag of the youngest in-flight instruction that will write that register. When an instruction is issued, the block looks up its two source registers and returns, one cycle later, each source's value, whether that value is final, and which tag to wait for if it is not. In the same cycle it records the issuing instruction as the new producer of its destination register.

When the reorder buffer retires an instruction, the committed result is written into the register file. The pending flag is cleared only if the retiring instruction is still the youngest producer of that register. A flush request discards all rename state. Every register becomes final with tag zero, and the committed values are kept.

Top module: `rename_regfile`

## Requirements
- R1: After reset every register holds 0, is not pending and has tag 0. The result outputs show valid 0, data 0, ready 1 and tag 0.
- R2: Register index 0 always reads as data 0, ready 1, tag 0. A commit to it is ignored, and using it as a destination never makes it pending.
- R3: An issue with no flush raises `src_valid_o` on the following cycle. For each present source field, that cycle carries the register's value, its ready state (1 means not pending) and its producer tag. The lookup reflects the state before this cycle's rename.
- R4: A source whose field-present input is 0 reports data 0, ready 1 and tag 0. The same idle result appears on both sources in any cycle with no accepted issue.
- R5: An issue with a present, nonzero destination stores the issuing tag as that register's producer and marks it pending.
- R6: A commit to a nonzero register writes the committed data into it, whatever its tag.
- R7: A commit clears the register's pending state only when the stored producer tag equals the commit tag. On a mismatch the register stays pending with its tag unchanged.
- R8: When a commit and an accepted issue with that register as destination occur in the same cycle, the register ends pending with the new issuing tag and holds the committed data.
- R9: A source read in the same cycle as a commit to that register returns the committed data. It reports ready if the register was already ready or the commit tag equals its producer tag.
- R10: A flush sets every tag to 0 and every register to ready, keeping the stored values. A commit in the flush cycle still writes its data.
- R11: During a flush, issue is ignored. No destination is renamed, and on the next cycle `src_valid_o` is 0 with idle source results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Discard all rename state |
| issue_valid_i | input | 1 | An instruction is issuing this cycle |
| issue_tag_i | input | TAG_W | Reorder-buffer index of the issuing instruction |
| rs1_valid_i | input | 1 | First source field present |
| rs1_idx_i | input | IDX_W | First source register |
| rs2_valid_i | input | 1 | Second source field present |
| rs2_idx_i | input | IDX_W | Second source register |
| rd_valid_i | input | 1 | Destination field present |
| rd_idx_i | input | IDX_W | Destination register |
| commit_valid_i | input | 1 | An instruction retires this cycle |
| commit_idx_i | input | IDX_W | Register written by the retiring instruction |
| commit_tag_i | input | TAG_W | Reorder-buffer index of the retiring instruction |
| commit_data_i | input | DATA_W | Committed result |
| src_valid_o | output | 1 | Source results below belong to last cycle's issue |
| rs1_data_o | output | DATA_W | First source value |
| rs1_ready_o | output | 1 | First source value is final |
| rs1_tag_o | output | TAG_W | Producer tag of first source |
| rs2_data_o | output | DATA_W | Second source value |
| rs2_ready_o | output | 1 | Second source value is final |
| rs2_tag_o | output | TAG_W | Producer tag of second source |

## Verification
Source results for an issue presented before a rising edge are registered on that edge. They are due exactly one edge later. A rename, commit or flush changes the state on that same edge, so its effect appears in the results of an issue made in the next cycle. The bench drives every input set on a falling edge and predicts that cycle's results from a model updated in requirement order. It lets one rising edge pass and compares on the following falling edge, so each comparison sits a half period away from the edge that produced it.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
    localparam int unsigned RRF_NREG   = 32;
    localparam int unsigned RRF_TAG_W  = 5;
    localparam int unsigned RRF_DATA_W = 32;
    localparam int unsigned RRF_NSRC   = 2;
endpackage

// File: rtl/rrf_src_read.sv
module rrf_src_read #(
    parameter int unsigned NREG   = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 5,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic                             lookup_i,
    input  logic [IDX_W-1:0]                 idx_i,
    input  logic [NREG-1:0][DATA_W-1:0]      regs_i,
    input  logic [NREG-1:0][TAG_W-1:0]       tags_i,
    input  logic [NREG-1:0]                  ready_i,
    input  logic                             cm_valid_i,
    input  logic [IDX_W-1:0]                 cm_idx_i,
    input  logic [TAG_W-1:0]                 cm_tag_i,
    input  logic [DATA_W-1:0]                cm_data_i,
    output logic [DATA_W-1:0]                data_o,
    output logic                             ready_o,
    output logic [TAG_W-1:0]                 tag_o
);
    always_comb begin
        data_o  = '0;
        ready_o = 1'b1;
        tag_o   = '0;
        if (lookup_i && (idx_i != '0)) begin
            tag_o = tags_i[idx_i];
            if (cm_valid_i && (cm_idx_i == idx_i)) begin
                data_o  = cm_data_i;
                ready_o = ready_i[idx_i] || (tags_i[idx_i] == cm_tag_i);
            end else begin
                data_o  = regs_i[idx_i];
                ready_o = ready_i[idx_i];
            end
        end
    end
endmodule

// File: rtl/rename_regfile.sv
module rename_regfile #(
    parameter int unsigned NREG   = rrf_pkg::RRF_NREG,
    parameter int unsigned TAG_W  = rrf_pkg::RRF_TAG_W,
    parameter int unsigned DATA_W = rrf_pkg::RRF_DATA_W,
    localparam int unsigned IDX_W = $clog2(NREG),
    localparam int unsigned NSRC  = rrf_pkg::RRF_NSRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              issue_valid_i,
    input  logic [TAG_W-1:0]  issue_tag_i,
    input  logic              rs1_valid_i,
    input  logic [IDX_W-1:0]  rs1_idx_i,
    input  logic              rs2_valid_i,
    input  logic [IDX_W-1:0]  rs2_idx_i,
    input  logic              rd_valid_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic              commit_valid_i,
    input  logic [IDX_W-1:0]  commit_idx_i,
    input  logic [TAG_W-1:0]  commit_tag_i,
    input  logic [DATA_W-1:0] commit_data_i,
    output logic              src_valid_o,
    output logic [DATA_W-1:0] rs1_data_o,
    output logic              rs1_ready_o,
    output logic [TAG_W-1:0]  rs1_tag_o,
    output logic [DATA_W-1:0] rs2_data_o,
    output logic              rs2_ready_o,
    output logic [TAG_W-1:0]  rs2_tag_o
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic [NREG-1:0][TAG_W-1:0]  tags;
        logic [NREG-1:0]             ready;
        logic                        out_valid;
        logic [NSRC-1:0][DATA_W-1:0] out_data;
        logic [NSRC-1:0]             out_ready;
        logic [NSRC-1:0][TAG_W-1:0]  out_tag;
    } state_t;

    state_t st_d, st_q;

    logic                         issue_live;
    logic                         cm_live;
    logic                         rd_hits_commit;
    logic [NSRC-1:0]              src_fv;
    logic [NSRC-1:0][IDX_W-1:0]   src_idx;
    logic [NSRC-1:0][DATA_W-1:0]  rd_data;
    logic [NSRC-1:0]              rd_ready;
    logic [NSRC-1:0][TAG_W-1:0]   rd_tag;

    assign issue_live     = issue_valid_i && !flush_i;
    assign cm_live        = commit_valid_i && (commit_idx_i != '0);
    assign rd_hits_commit = issue_live && rd_valid_i && (rd_idx_i == commit_idx_i);
    assign src_fv         = {rs2_valid_i, rs1_valid_i};
    assign src_idx        = {rs2_idx_i, rs1_idx_i};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        rrf_src_read #(
            .NREG   (NREG),
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
        ) u_read (
            .lookup_i   (issue_live && src_fv[s]),
            .idx_i      (src_idx[s]),
            .regs_i     (st_q.regs),
            .tags_i     (st_q.tags),
            .ready_i    (st_q.ready),
            .cm_valid_i (commit_valid_i),
            .cm_idx_i   (commit_idx_i),
            .cm_tag_i   (commit_tag_i),
            .cm_data_i  (commit_data_i),
            .data_o     (rd_data[s]),
            .ready_o    (rd_ready[s]),
            .tag_o      (rd_tag[s])
        );
    end

    always_comb begin
        st_d = st_q;
        // retire path: value always lands, pending cleared only for youngest writer
        if (cm_live) begin
            st_d.regs[commit_idx_i] = commit_data_i;
            if ((st_q.tags[commit_idx_i] == commit_tag_i) && !rd_hits_commit)
                st_d.ready[commit_idx_i] = 1'b1;
        end
        if (flush_i) begin
            st_d.tags      = '0;
            st_d.ready     = '1;
            st_d.out_valid = 1'b0;
            st_d.out_data  = '0;
            st_d.out_ready = '1;
            st_d.out_tag   = '0;
        end else begin
            st_d.out_valid = issue_valid_i;
            st_d.out_data  = rd_data;
            st_d.out_ready = rd_ready;
            st_d.out_tag   = rd_tag;
            if (issue_valid_i && rd_valid_i && (rd_idx_i != '0)) begin
                st_d.tags[rd_idx_i]  = issue_tag_i;
                st_d.ready[rd_idx_i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.regs      <= '0;
            st_q.tags      <= '0;
            st_q.ready     <= '1;
            st_q.out_valid <= 1'b0;
            st_q.out_data  <= '0;
            st_q.out_ready <= '1;
            st_q.out_tag   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_valid_o = st_q.out_valid;
    assign rs1_data_o  = st_q.out_data[0];
    assign rs1_ready_o = st_q.out_ready[0];
    assign rs1_tag_o   = st_q.out_tag[0];
    assign rs2_data_o  = st_q.out_data[1];
    assign rs2_ready_o = st_q.out_ready[1];
    assign rs2_tag_o   = st_q.out_tag[1];
endmodule

// File: rtl/rrf_checker.sv
module rrf_checker #(
    parameter int unsigned NREG   = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic              issue_valid_i,
    input logic              rs1_valid_i,
    input logic [IDX_W-1:0]  rs1_idx_i,
    input logic              rd_valid_i,
    input logic [IDX_W-1:0]  rd_idx_i,
    input logic              src_valid_o,
    input logic [DATA_W-1:0] rs1_data_o,
    input logic              rs1_ready_o,
    input logic [NREG-1:0]   ready_vec
);
    AST_FLUSH_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !src_valid_o); // R11
    AST_ISSUE_RESULT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && !flush_i) |=> src_valid_o); // R3
    AST_ABSENT_SRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && !flush_i && !rs1_valid_i) |=> (rs1_ready_o && (rs1_data_o == '0))); // R4
    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && !flush_i && rs1_valid_i && (rs1_idx_i == '0)) |=> (rs1_ready_o && (rs1_data_o == '0))); // R2
    AST_RENAME_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && !flush_i && rd_valid_i && (rd_idx_i != '0)) |=> !ready_vec[$past(rd_idx_i)]); // R8
    AST_FLUSH_ALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (&ready_vec)); // R10
    AST_ZERO_NEVER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ready_vec[0]); // R2
endmodule

bind rename_regfile rrf_checker #(
    .NREG   (NREG),
    .DATA_W (DATA_W)
) u_rrf_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .issue_valid_i (issue_valid_i),
    .rs1_valid_i   (rs1_valid_i),
    .rs1_idx_i     (rs1_idx_i),
    .rd_valid_i    (rd_valid_i),
    .rd_idx_i      (rd_idx_i),
    .src_valid_o   (src_valid_o),
    .rs1_data_o    (rs1_data_o),
    .rs1_ready_o   (rs1_ready_o),
    .ready_vec     (st_q.ready)
);

// File: tb/tb_rename_regfile.sv
`timescale 1ns/1ps
module tb_rename_regfile;
    localparam int NREG = 32;
    localparam int TW = 5;
    localparam int DW = 32;
    localparam int IW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush, iv, s1v, s2v, rdv, cv;
    logic [TW-1:0] itag, ctag;
    logic [IW-1:0] s1i, s2i, rdi, ci;
    logic [DW-1:0] cdata;
    logic sv_o, r1_o, r2_o;
    logic [DW-1:0] d1_o, d2_o;
    logic [TW-1:0] t1_o, t2_o;

    logic [DW-1:0] m_regs [NREG];
    logic [TW-1:0] m_tag [NREG];
    logic          m_rdy [NREG];

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    rename_regfile dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .issue_valid_i(iv), .issue_tag_i(itag),
        .rs1_valid_i(s1v), .rs1_idx_i(s1i),
        .rs2_valid_i(s2v), .rs2_idx_i(s2i),
        .rd_valid_i(rdv), .rd_idx_i(rdi),
        .commit_valid_i(cv), .commit_idx_i(ci), .commit_tag_i(ctag), .commit_data_i(cdata),
        .src_valid_o(sv_o),
        .rs1_data_o(d1_o), .rs1_ready_o(r1_o), .rs1_tag_o(t1_o),
        .rs2_data_o(d2_o), .rs2_ready_o(r2_o), .rs2_tag_o(t2_o)
    );

    // expected {data, ready, tag} for one source
    function automatic logic [DW+TW:0] exp_src(input logic fv, input logic [IW-1:0] idx);
        if (!(iv && !flush) || !fv || idx == 0) return {{DW{1'b0}}, 1'b1, {TW{1'b0}}};
        if (cv && ci == idx) return {cdata, m_rdy[idx] | (m_tag[idx] == ctag), m_tag[idx]};
        return {m_regs[idx], m_rdy[idx], m_tag[idx]};
    endfunction

    task automatic idle();
        flush = 0; iv = 0; s1v = 0; s2v = 0; rdv = 0; cv = 0;
        itag = 0; ctag = 0; s1i = 0; s2i = 0; rdi = 0; ci = 0; cdata = 0;
    endtask

    task automatic check(input string lbl, input logic [2*(DW+TW+1):0] act, input logic [2*(DW+TW+1):0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
        end
    endtask

    // apply current inputs for one cycle, update model, compare results
    task automatic step(input string lbl);
        logic [DW+TW:0] e1, e2;
        logic ev;
        ev = iv && !flush;
        e1 = exp_src(s1v, s1i);
        e2 = exp_src(s2v, s2i);
        if (cv && ci != 0) begin
            m_regs[ci] = cdata;
            if (m_tag[ci] == ctag && !(iv && !flush && rdv && rdi == ci)) m_rdy[ci] = 1'b1;
        end
        if (flush) begin
            for (int k = 0; k < NREG; k++) begin m_tag[k] = 0; m_rdy[k] = 1'b1; end
        end else if (iv && rdv && rdi != 0) begin
            m_tag[rdi] = itag; m_rdy[rdi] = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        check(lbl, {sv_o, d1_o, r1_o, t1_o, d2_o, r2_o, t2_o}, {ev, e1, e2});
        idle();
    endtask

    task automatic rd2(input logic [IW-1:0] a, input logic [IW-1:0] b, input string lbl);
        iv = 1; s1v = 1; s1i = a; s2v = 1; s2i = b;
        step(lbl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        idle();
        for (int k = 0; k < NREG; k++) begin m_regs[k] = 0; m_tag[k] = 0; m_rdy[k] = 1'b1; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check("R1", {sv_o, d1_o, r1_o, t1_o, d2_o, r2_o, t2_o},
              {1'b0, {DW{1'b0}}, 1'b1, {TW{1'b0}}, {DW{1'b0}}, 1'b1, {TW{1'b0}}});
        rd2(5, 31, "R1");
        // R3/R4: one source absent
        iv = 1; s1v = 1; s1i = 3; s2v = 0; s2i = 7; step("R4");
        // R5: rename x5 with tag 7
        iv = 1; rdv = 1; rdi = 5; itag = 7; step("R5");
        rd2(5, 4, "R5");
        // R6/R7: mismatching commit writes value, stays pending
        cv = 1; ci = 5; ctag = 3; cdata = 32'hAAAA_0001; step("R6");
        rd2(5, 0, "R7");
        cv = 1; ci = 5; ctag = 7; cdata = 32'hBBBB_0002; step("R7");
        rd2(5, 5, "R7");
        // R2: x0 rename and commit ignored
        iv = 1; rdv = 1; rdi = 0; itag = 9; step("R2");
        cv = 1; ci = 0; ctag = 0; cdata = 32'hFFFF_FFFF; step("R2");
        rd2(0, 0, "R2");
        // R8: commit and rename same register together
        iv = 1; rdv = 1; rdi = 6; itag = 4; step("R8");
        iv = 1; rdv = 1; rdi = 6; itag = 12; cv = 1; ci = 6; ctag = 4; cdata = 32'h0000_0011; step("R8");
        rd2(6, 6, "R8");
        // R9: same-cycle bypass
        iv = 1; rdv = 1; rdi = 8; itag = 2; step("R9");
        iv = 1; s1v = 1; s1i = 8; s2v = 1; s2i = 6; cv = 1; ci = 8; ctag = 2; cdata = 32'h0000_0055; step("R9");
        iv = 1; s1v = 1; s1i = 6; cv = 1; ci = 6; ctag = 30; cdata = 32'h0000_0066; step("R9");
        // R10: flush keeps values, clears tags; commit in flush cycle lands
        iv = 1; rdv = 1; rdi = 9; itag = 1; step("R10");
        flush = 1; cv = 1; ci = 11; ctag = 17; cdata = 32'h0000_0077; step("R10");
        rd2(9, 11, "R10");
        rd2(6, 8, "R10");
        // R11: issue suppressed during flush
        flush = 1; iv = 1; rdv = 1; rdi = 12; itag = 5; s1v = 1; s1i = 9; step("R11");
        rd2(12, 9, "R11");
        // constrained random traffic on a small register window
        for (int n = 0; n < 600; n++) begin
            string lbl;
            flush = ($urandom_range(0, 31) == 0);
            iv = ($urandom_range(0, 3) != 0);
            s1v = $urandom_range(0, 1); s1i = IW'($urandom_range(0, 7));
            s2v = $urandom_range(0, 1); s2i = IW'($urandom_range(0, 7));
            rdv = $urandom_range(0, 1); rdi = IW'($urandom_range(0, 7));
            itag = TW'($urandom);
            cv = $urandom_range(0, 1); ci = IW'($urandom_range(0, 7));
            ctag = $urandom_range(0, 1) ? m_tag[ci] : TW'($urandom);
            cdata = $urandom;
            if (flush) lbl = "R11";
            else if (cv && iv && ((s1v && s1i == ci) || (s2v && s2i == ci))) lbl = "R9";
            else if (cv && iv && rdv && rdi == ci) lbl = "R8";
            else lbl = "R3";
            step(lbl);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule